// File: doc/BRIEF.md
# Three-Master Bus Arbiter

This block decides which of three masters owns a shared bus: a network controller, a DMA engine and a CPU. Each master raises a request line and receives a grant line. Ownership is decided only when a cycle-boundary strobe is high, and the grant that results holds until the next strobe.

Three control inputs shape each decision. A priority-select bit chooses between two fixed orderings. An assume-request bit makes the current owner take part in arbitration as though it were still requesting. If that owner would win without actually requesting, the bus passes through one empty boundary period, marked by a dead-cycle flag, before it is handed on. A lock bit freezes ownership with the current owner for as long as the bit is set.

Request and grant vectors use bit 0 for the network controller, bit 1 for the DMA engine and bit 2 for the CPU.

Top module: `bus_arb3`

## Requirements
- R1: `grant` has at most one bit set at all times. After reset, `grant` is 3'b000 and `dead_cycle` is 0.
- R2: `grant` and `dead_cycle` change only on a rising clock edge at which `boundary` is 1.
- R3: With `prio_cpu_first` = 0 and lock not in force, the winner is the highest requester in the order network (bit 0), then DMA (bit 1), then CPU (bit 2).
- R4: With `prio_cpu_first` = 1 and lock not in force, the winner is the highest requester in the order CPU (bit 2), then DMA (bit 1), then network (bit 0).
- R5: With `assume_req` = 0, the owner keeps the bus only if it requests and wins again. When no master requests, the bus is parked with `grant` = 3'b000.
- R6: With `assume_req` = 1, the owner counts as a requester. A higher-ranked active requester takes the bus at the next boundary with no dead cycle. An owner that requests and outranks the others keeps the bus.
- R7: With `assume_req` = 1, if the owner is not requesting but would still win, the next boundary gives `grant` = 3'b000 and `dead_cycle` = 1. The boundary after that arbitrates among the active requests only.
- R8: While `lock_bus` = 1 and a master owns the bus, that owner keeps the grant at every boundary, whatever the requests are.
- R9: After `lock_bus` returns to 0, the next boundary arbitrates normally.
- R10: While `lock_bus` = 1 and no master owns the bus (parked or dead cycle), a boundary arbitrates normally, and the winner is then held by the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| boundary | input | 1 | Cycle-boundary strobe; arbitration happens only when it is high |
| req | input | 3 | Requests: bit 0 network, bit 1 DMA, bit 2 CPU |
| prio_cpu_first | input | 1 | 0: network > DMA > CPU; 1: CPU > DMA > network |
| assume_req | input | 1 | Treat the current owner as requesting |
| lock_bus | input | 1 | Freeze ownership with the current owner |
| grant | output | 3 | One-hot grant, same bit order as `req` |
| dead_cycle | output | 1 | High during the idle boundary period caused by assume-request |

## Verification
The two functions that can meet in one cycle are the assume-request dead cycle and the bus lock. The bench sets `lock_bus` during a dead period, when no master owns the bus, and requests from both the DMA engine and the CPU. It then expects the next boundary to grant the DMA engine by priority and later boundaries to hold that grant while the lock stays set. The bench also changes the requests and the priority bit between strobes, to show that the grant does not move without a boundary.

// File: rtl/bus_arb3.sv
module bus_arb3 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       boundary,
  input  logic [2:0] req,
  input  logic       prio_cpu_first,
  input  logic       assume_req,
  input  logic       lock_bus,
  output logic [2:0] grant,
  output logic       dead_cycle
);

  logic [2:0] grant_q, grant_d, cand, win;
  logic       dead_q, dead_d;
  logic       owned, owner_req, owner_wins;

  function automatic logic [2:0] pick(input logic [2:0] c, input logic cpu_first);
    if (!cpu_first)
      pick = c[0] ? 3'b001 : c[1] ? 3'b010 : c[2] ? 3'b100 : 3'b000;
    else
      pick = c[2] ? 3'b100 : c[1] ? 3'b010 : c[0] ? 3'b001 : 3'b000;
  endfunction

  assign owned      = |grant_q;
  assign cand       = req | (assume_req ? grant_q : 3'b000);
  assign win        = pick(cand, prio_cpu_first);
  assign owner_req  = |(req & grant_q);
  assign owner_wins = |(win & grant_q);

  always_comb begin
    grant_d = win;
    dead_d  = 1'b0;
    if (lock_bus && owned) begin
      grant_d = grant_q;
    end else if (assume_req && owner_wins && !owner_req) begin
      grant_d = 3'b000;
      dead_d  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= 3'b000;
      dead_q  <= 1'b0;
    end else if (boundary) begin
      grant_q <= grant_d;
      dead_q  <= dead_d;
    end
  end

  assign grant      = grant_q;
  assign dead_cycle = dead_q;

endmodule

module bus_arb3_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       boundary,
  input logic [2:0] req,
  input logic       prio_cpu_first,
  input logic       lock_bus,
  input logic [2:0] grant,
  input logic       dead_cycle
);

  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !boundary |=> ($stable(grant) && $stable(dead_cycle)));

  a_r3_net_top: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !lock_bus && !prio_cpu_first && req[0]) |=> grant == 3'b001);

  a_r4_cpu_top: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !lock_bus && prio_cpu_first && req[2]) |=> grant == 3'b100);

  a_r7_dead_idle: assert property (@(posedge clk) disable iff (!rst_n)
    dead_cycle |-> grant == 3'b000);

  a_r8_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && lock_bus && |grant) |=> $stable(grant));

endmodule

bind bus_arb3 bus_arb3_chk u_chk (
  .clk(clk), .rst_n(rst_n), .boundary(boundary), .req(req),
  .prio_cpu_first(prio_cpu_first), .lock_bus(lock_bus),
  .grant(grant), .dead_cycle(dead_cycle)
);

// File: tb/tb_bus_arb3.sv
module tb_bus_arb3;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, boundary = 1'b0;
  logic [2:0] req = 3'b000;
  logic prio_cpu_first = 1'b0, assume_req = 1'b0, lock_bus = 1'b0;
  logic [2:0] grant;
  logic dead_cycle;
  int n_chk = 0, n_fail = 0;

  bus_arb3 dut (.clk(clk), .rst_n(rst_n), .boundary(boundary), .req(req),
    .prio_cpu_first(prio_cpu_first), .assume_req(assume_req),
    .lock_bus(lock_bus), .grant(grant), .dead_cycle(dead_cycle));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [2:0] g_exp, input logic d_exp);
    n_chk++;
    if (grant !== g_exp || dead_cycle !== d_exp) begin
      n_fail++;
      $display("FAIL %s: grant=%b dead=%b expected grant=%b dead=%b",
               tag, grant, dead_cycle, g_exp, d_exp);
    end
  endtask

  task automatic step(input logic [2:0] r);
    @(negedge clk); req = r; boundary = 1'b1;
    @(posedge clk); @(negedge clk); boundary = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0; boundary = 1'b0; req = 3'b000;
    prio_cpu_first = 1'b0; assume_req = 1'b0; lock_bus = 1'b0;
    idle(2); rst_n = 1'b1; idle(1);
  endtask

  task automatic t_reset;
    do_reset();
    chk("R1 reset", 3'b000, 1'b0);
  endtask

  task automatic t_priority;
    do_reset();
    step(3'b111); chk("R3 all request order0", 3'b001, 1'b0);
    step(3'b110); chk("R3 dma over cpu", 3'b010, 1'b0);
    prio_cpu_first = 1'b1;
    step(3'b111); chk("R4 all request order1", 3'b100, 1'b0);
    step(3'b011); chk("R4 dma over net", 3'b010, 1'b0);
  endtask

  task automatic t_boundary_only;
    do_reset();
    step(3'b100); chk("R2 cpu granted", 3'b100, 1'b0);
    @(negedge clk); req = 3'b001; prio_cpu_first = 1'b1;
    idle(3); chk("R2 no change without strobe", 3'b100, 1'b0);
    step(3'b001); chk("R2 change at strobe", 3'b001, 1'b0);
  endtask

  task automatic t_release;
    do_reset();
    step(3'b001); chk("R5 net owner", 3'b001, 1'b0);
    step(3'b100); chk("R5 owner releases", 3'b100, 1'b0);
    step(3'b000); chk("R5 park", 3'b000, 1'b0);
  endtask

  task automatic t_assume;
    do_reset(); assume_req = 1'b1;
    step(3'b100); chk("R6 cpu owner", 3'b100, 1'b0);
    step(3'b001); chk("R6 outranked without dead", 3'b001, 1'b0);
    step(3'b101); chk("R6 requesting owner keeps", 3'b001, 1'b0);
    step(3'b110); chk("R7 dead cycle", 3'b000, 1'b1);
    step(3'b110); chk("R7 after dead", 3'b010, 1'b0);
  endtask

  task automatic t_lock;
    do_reset();
    step(3'b010); chk("R8 dma owner", 3'b010, 1'b0);
    lock_bus = 1'b1;
    step(3'b101); chk("R8 locked", 3'b010, 1'b0);
    step(3'b000); chk("R8 still locked", 3'b010, 1'b0);
    lock_bus = 1'b0;
    step(3'b101); chk("R9 unlocked", 3'b001, 1'b0);
    step(3'b000); chk("R9 park", 3'b000, 1'b0);
    lock_bus = 1'b1;
    step(3'b100); chk("R10 lock from park", 3'b100, 1'b0);
    step(3'b001); chk("R10 held", 3'b100, 1'b0);
  endtask

  task automatic t_lock_in_dead;
    do_reset(); assume_req = 1'b1;
    step(3'b001); chk("R6 net owner", 3'b001, 1'b0);
    step(3'b010); chk("R7 dead", 3'b000, 1'b1);
    lock_bus = 1'b1;
    step(3'b110); chk("R10 lock during dead", 3'b010, 1'b0);
    step(3'b101); chk("R8 lock holds after dead", 3'b010, 1'b0);
  endtask

  initial begin
    fork
      begin
        t_reset(); t_priority(); t_boundary_only(); t_release();
        t_assume(); t_lock(); t_lock_in_dead();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: run did not finish");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule